// File: doc/BRIEF.md
# Table-Driven AES Column Mixing Stage

This block performs the column-mixing step of the AES encryption round on a whole 128-bit state in one pass. The state is treated as four 32-bit columns. Each byte is an element of GF(2^8) reduced by x^8 + x^4 + x^3 + x + 1, and every column is multiplied by a fixed 4x4 circulant matrix. The doubled and tripled form of each input byte comes from two constant 256-entry, 8-bit lookup tables. Shift-and-XOR multiply logic is not used. Every output byte is then a single four-input XOR of two table outputs and two unmodified input bytes.

The stage sits between row shifting and key addition in a round pipeline. The input is a state word with a valid flag. A parameter decides whether the result leaves combinationally in the same cycle or through an output register that carries the valid flag with it.

Top module: `mix_columns_rom`

## Requirements
- R1: The state is held with byte k at bits [127-8k -: 8], and column c holds bytes 4c to 4c+3 with its byte 0 at the most significant position. For input column bytes (a0,a1,a2,a3), output column bytes are o0=2a0^3a1^a2^a3, o1=a0^2a1^3a2^a3, o2=a0^a1^2a2^3a3 and o3=3a0^a1^a2^2a3.
- R2: All four columns are transformed in the same cycle and independently. Changing the bytes of one column changes only that column's output.
- R3: The doubling table gives 2b = {b[6:0],0} XOR (0x1B if b[7] is 1), and the tripling table gives 3b = 2b XOR b. This holds for every byte value, including 0x00, 0x80 and 0xFF.
- R4: Column 0xdb135345 maps to 0x8e4da1bc, column 0xf20a225c maps to 0x9fdc589d, an all-zero state maps to all-zero, and an all-0xFF state maps to all-0xFF.
- R5: With REGISTER_OUT=1, out_state and out_valid show the result of an input accepted at a rising edge after that edge, a latency of one cycle. While rst_n is low, out_valid and out_state are both zero.
- R6: With REGISTER_OUT=1, a cycle with in_valid low drives out_valid low after the next edge and leaves out_state unchanged.
- R7: With REGISTER_OUT=0, out_state is the transform of in_state and out_valid equals in_valid within the same cycle.
- R8: In every column, the XOR of the four output bytes equals the XOR of the four input bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge, used by the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| in_valid | input | 1 | Input state is valid this cycle |
| in_state | input | 128 | State to be mixed, byte 0 in the top bits |
| out_valid | output | 1 | Output state is valid |
| out_state | output | 128 | Mixed state |

## Verification
Loading the output register and holding it can fall in adjacent cycles of one stream. The transform of all four columns also falls in a single cycle. The bench interleaves valid and idle cycles at random, with a fixed seed, and alternates back-to-back valid inputs with gaps. It checks the registered and the combinational instances against a shift-and-add GF(2^8) model. It also perturbs one column at a time and confirms that the other three columns' outputs do not move.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int BYTE_W   = 8;
  localparam int COL_B    = 4;
  localparam int TBL_N    = 1 << BYTE_W;
  localparam logic [BYTE_W-1:0] RED_POLY = 8'h1B;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t tbl_t [TBL_N];

  function automatic byte_t gf_dbl(input byte_t b);
    byte_t r;
    r = {b[BYTE_W-2:0], 1'b0};
    if (b[BYTE_W-1]) r = r ^ RED_POLY;
    return r;
  endfunction

  function automatic byte_t gf_tpl(input byte_t b);
    return gf_dbl(b) ^ b;
  endfunction

  function automatic tbl_t build_tbl(input int factor);
    tbl_t t;
    for (int i = 0; i < TBL_N; i++) begin
      if (factor == 3) t[i] = gf_tpl(byte_t'(i));
      else             t[i] = gf_dbl(byte_t'(i));
    end
    return t;
  endfunction
endpackage

// File: rtl/mc_lut.sv
`timescale 1ns/1ps
module mc_lut
  import mc_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] dbl_out,
  output logic [BYTE_W-1:0] tpl_out
);
  localparam tbl_t DBL_TBL = build_tbl(2);
  localparam tbl_t TPL_TBL = build_tbl(3);

  assign dbl_out = DBL_TBL[byte_in];
  assign tpl_out = TPL_TBL[byte_in];

  always_comb begin
    if (!$isunknown(byte_in)) begin
      AST_TPL_FROM_DBL: assert (tpl_out == (dbl_out ^ byte_in)); // R3
      AST_DBL_CARRY_BIT: assert (dbl_out[0] == byte_in[BYTE_W-1]); // R3
    end
  end
endmodule

// File: rtl/mc_column.sv
`timescale 1ns/1ps
module mc_column
  import mc_pkg::*;
(
  input  logic [COL_B*BYTE_W-1:0] col_in,
  output logic [COL_B*BYTE_W-1:0] col_out
);
  localparam int CW = COL_B * BYTE_W;

  byte_t b   [COL_B];
  byte_t x2  [COL_B];
  byte_t x3  [COL_B];
  byte_t o   [COL_B];

  for (genvar i = 0; i < COL_B; i++) begin : g_byte
    assign b[i] = col_in[CW-1-BYTE_W*i -: BYTE_W];
    mc_lut u_lut (
      .byte_in (b[i]),
      .dbl_out (x2[i]),
      .tpl_out (x3[i])
    );
    assign o[i] = x2[i] ^ x3[(i+1)%COL_B] ^ b[(i+2)%COL_B] ^ b[(i+3)%COL_B];
    assign col_out[CW-1-BYTE_W*i -: BYTE_W] = o[i];
  end

  wire [BYTE_W-1:0] in_fold  = b[0] ^ b[1] ^ b[2] ^ b[3];
  wire [BYTE_W-1:0] out_fold = o[0] ^ o[1] ^ o[2] ^ o[3];

  always_comb begin
    if (!$isunknown(col_in)) begin
      AST_COL_FOLD: assert (out_fold == in_fold); // R8
    end
  end
endmodule

// File: rtl/mc_outreg.sv
`timescale 1ns/1ps
module mc_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R5
  AST_LOAD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid) |-> out_data == $past(in_data)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(out_data)); // R6
endmodule

// File: rtl/mix_columns_rom.sv
`timescale 1ns/1ps
module mix_columns_rom #(
  parameter int NCOL         = 4,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  input  logic [NCOL*mc_pkg::COL_B*mc_pkg::BYTE_W-1:0] in_state,
  output logic                                 out_valid,
  output logic [NCOL*mc_pkg::COL_B*mc_pkg::BYTE_W-1:0] out_state
);
  localparam int CW      = mc_pkg::COL_B * mc_pkg::BYTE_W;
  localparam int STATE_W = NCOL * CW;

  logic [STATE_W-1:0] mixed;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    mc_column u_col (
      .col_in  (in_state[STATE_W-1-CW*c -: CW]),
      .col_out (mixed[STATE_W-1-CW*c -: CW])
    );
  end

  if (REGISTER_OUT) begin : g_reg
    mc_outreg #(.W(STATE_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (mixed),
      .out_valid (out_valid),
      .out_data  (out_state)
    );
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_state = mixed;
  end
endmodule

// File: tb/mix_columns_rom_tb.sv
`timescale 1ns/1ps
module mix_columns_rom_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [127:0] in_state = '0;
  logic out_valid, c_valid;
  logic [127:0] out_state, c_state;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [127:0] exp_state = '0;
  logic exp_valid = 1'b0;

  always #2.5 clk = ~clk;

  mix_columns_rom #(.REGISTER_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
    .out_valid(out_valid), .out_state(out_state));

  mix_columns_rom #(.REGISTER_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
    .out_valid(c_valid), .out_state(c_state));

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] k);
    logic [7:0] p = 0;
    logic [7:0] aa = a;
    logic [7:0] kk = k;
    for (int i = 0; i < 8; i++) begin
      if (kk[0]) p ^= aa;
      aa = aa[7] ? ((aa << 1) ^ 8'h1B) : (aa << 1);
      kk = kk >> 1;
    end
    return p;
  endfunction

  function automatic logic [127:0] ref_mix(input logic [127:0] s);
    logic [127:0] r;
    logic [7:0] m [4][4];
    logic [7:0] a [4];
    logic [7:0] acc;
    m = '{'{2,3,1,1}, '{1,2,3,1}, '{1,1,2,3}, '{3,1,1,2}};
    for (int c = 0; c < 4; c++) begin
      for (int j = 0; j < 4; j++) a[j] = s[127 - 8*(4*c+j) -: 8];
      for (int i = 0; i < 4; i++) begin
        acc = 0;
        for (int j = 0; j < 4; j++) acc ^= gmul(a[j], m[i][j]);
        r[127 - 8*(4*c+i) -: 8] = acc;
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // registered check of previous cycle, then drive, then combinational check
  task automatic step(input logic v, input logic [127:0] s, input string tag);
    @(negedge clk);
    chk({tag, " R5 reg valid"}, {127'b0, out_valid}, {127'b0, exp_valid});
    chk({tag, " R5/R6 reg state"}, out_state, exp_state);
    in_valid = v;
    in_state = s;
    #1;
    chk({tag, " R7 comb valid"}, {127'b0, c_valid}, {127'b0, v});
    chk({tag, " R7 comb state"}, c_state, ref_mix(s));
    exp_valid = v;
    if (v) exp_state = ref_mix(s);
  endtask

  initial begin
    logic [127:0] base, pert, r0, r1;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R5 reset valid", {127'b0, out_valid}, 128'b0);
    chk("R5 reset state", out_state, 128'b0);
    rst_n = 1'b1;

    // R4 known columns
    step(1, {32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6}, "R4 vec");
    @(negedge clk);
    chk("R4 col db135345", {96'b0, out_state[127:96]}, {96'b0, 32'h8e4da1bc});
    chk("R4 col f20a225c", {96'b0, out_state[95:64]}, {96'b0, 32'h9fdc589d});
    step(1, '0, "R4 zero");
    step(1, '1, "R4 ones");
    @(negedge clk);
    chk("R4 ones result", out_state, '1);
    // R3 table corners
    step(1, {8'h80, 8'h00, 8'h00, 8'h00, 8'hff, 8'h00, 8'h00, 8'h00,
             8'h7f, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00}, "R3 corner");
    @(negedge clk);
    chk("R3 2*80", {120'b0, out_state[127:120]}, {120'b0, 8'h1b});
    chk("R3 3*80", {120'b0, out_state[103:96]}, {120'b0, 8'h9b});
    chk("R3 2*ff", {120'b0, out_state[95:88]}, {120'b0, 8'he5});
    chk("R3 3*7f", {120'b0, out_state[39:32]}, {120'b0, 8'h81});

    // R6 idle hold with changing input
    step(0, 128'hdead_beef_0123_4567_89ab_cdef_5555_aaaa, "R6 idle");
    step(0, 128'h1234, "R6 idle2");

    // R2 column isolation
    base = {$urandom, $urandom, $urandom, $urandom};
    for (int c = 0; c < 4; c++) begin
      pert = base;
      pert[127-32*c -: 32] = ~pert[127-32*c -: 32];
      in_state = base; #1; r0 = c_state;
      in_state = pert; #1; r1 = c_state;
      for (int k = 0; k < 4; k++) begin
        if (k != c)
          chk("R2 untouched column", {96'b0, r1[127-32*k -: 32]}, {96'b0, r0[127-32*k -: 32]});
      end
    end

    // random mix of valid and idle, R1 R8 via reference
    for (int n = 0; n < 300; n++) begin
      step(($urandom % 4) != 0, {$urandom, $urandom, $urandom, $urandom}, "R1 random");
      r0 = c_state;
      for (int c = 0; c < 4; c++) begin
        chk("R8 column fold",
            {120'b0, r0[127-32*c -: 8] ^ r0[119-32*c -: 8] ^ r0[111-32*c -: 8] ^ r0[103-32*c -: 8]},
            {120'b0, in_state[127-32*c -: 8] ^ in_state[119-32*c -: 8] ^
                     in_state[111-32*c -: 8] ^ in_state[103-32*c -: 8]});
      end
    end
    step(0, '0, "R6 final");
    @(negedge clk);
    chk("R5 final valid", {127'b0, out_valid}, {127'b0, exp_valid});
    chk("R6 final state", out_state, exp_state);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 got=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule